// File: doc/BRIEF.md
# Shared-Memory Key-Check Coprocessor

This block is a hardware stand-in for a software key-validation routine. It owns the second port of a dual-port block RAM. A processor owns the first port. Nothing links the two sides except the RAM. Software copies a candidate key string into a data area and writes the value 1 into a lock word. The block keeps polling that lock word through its own port. When it sees the value 1, it reads a fixed number of data words and compares their bytes with a key held as a constant inside the circuit. It then writes a verdict into the first data word and writes 2 into the lock word, which hands control back to software.

The key length is fixed, so the block always reads the same number of words and takes the same number of cycles, whatever software placed in the data area. A long input therefore cannot reach past the compared bytes, and no control decision depends on an address taken from the data.

The layout has these fixed points:
- The lock word is the word directly after a base word address.
- The data area starts at a configurable byte offset from the base, 8 bytes by default.
- The RAM port returns read data one cycle after the read is issued.

Top module: `keychk_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the port enable `mem_en` and the write enable `mem_we` are both low.
- R2: While the lock word (word address BASE_WORD+1) holds any value other than 1, the block only issues reads of the lock word. It never writes the RAM.
- R3: Once the block reads lock value 1, it reads exactly NWORDS = ceil(KEY_LEN/4) data words. The reads are issued in ascending order, starting at word address BASE_WORD + DATA_OFS_BYTES/4.
- R4: Key byte k is compared with byte k%4 of data word k/4, where byte j of a word occupies bits [8j+7:8j] (little-endian). Any mismatched bit in any compared byte gives a failing verdict.
- R5: The verdict is written to the first data word. A full match writes PASS_VAL, which is nonzero and 1 by default. Any mismatch writes 0. No other address is written, except the lock word.
- R6: Bytes of the last data word at positions at or beyond KEY_LEN do not affect the verdict.
- R7: In the cycle directly after the verdict write, the block writes the value 2 to the lock word.
- R8: While the lock word holds 2, no new check starts: there are no data reads and no writes. A new check starts only after software writes 1 again.
- R9: The lock write is issued exactly 3*NWORDS+1 cycles after the read of the first data word, whatever the data contains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_en | output | 1 | RAM port enable |
| mem_we | output | 1 | RAM write enable (valid with mem_en) |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after a read |

## Verification
The bench builds the block with these parameters:
- ADDR_W=6, BASE_WORD=4, the default 8-byte data offset.
- KEY_LEN=10 with a fixed 80-bit key.

With these values the third data word holds two bytes that must be ignored. The bench sweeps both of those bytes through all 256 values behind a correct key. It also flips every single bit of all ten compared bytes, and tries byte-reversed words. This exercises the lane ordering, the verdict code, the fixed read count and the fixed latency, and it includes a partially filled last word.

// File: rtl/keychk_pkg.sv
package keychk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_LWAIT,
    ST_LCHK,
    ST_RD,
    ST_RWAIT,
    ST_CMP,
    ST_WRES,
    ST_WLOCK
  } kc_state_e;

  localparam int unsigned LOCK_GO   = 1;
  localparam int unsigned LOCK_DONE = 2;

endpackage

// File: rtl/keychk_match.sv
module keychk_match #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned KEY_LEN = 12,
  parameter logic [KEY_LEN*8-1:0] KEY = '0,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  widx,
  output logic              ok
);

  localparam int unsigned NB    = DATA_W / 8;
  localparam int unsigned NSLOT = 1 << IDX_W;

  logic [DATA_W-1:0] key_word [NSLOT];
  logic [DATA_W-1:0] key_mask [NSLOT];

  // Per-lane key byte and lane mask; lanes past the key length are masked off
  for (genvar w = 0; w < NSLOT; w++) begin : g_word
    for (genvar j = 0; j < NB; j++) begin : g_lane
      localparam int unsigned K = w * NB + j;
      if (K < KEY_LEN) begin : g_used
        assign key_word[w][8*j +: 8] = KEY[8*K +: 8];
        assign key_mask[w][8*j +: 8] = 8'hFF;
      end else begin : g_pad
        assign key_word[w][8*j +: 8] = 8'h00;
        assign key_mask[w][8*j +: 8] = 8'h00;
      end
    end
  end

  assign ok = ((word ^ key_word[widx]) & key_mask[widx]) == '0;

endmodule

// File: rtl/keychk_ctrl.sv
module keychk_ctrl
  import keychk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWORDS = 3,
  parameter int unsigned IDX_W  = 2,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 1,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 2,
  parameter logic [DATA_W-1:0] PASS_VAL  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_q,
  input  logic              word_ok,
  output logic              cap_en,
  output logic [IDX_W-1:0]  widx,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  kc_state_e st_q, st_nxt;
  logic      idx_clr, idx_inc, acc_set, acc_upd, acc_q;

  always_comb begin
    st_nxt    = st_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = LOCK_ADDR;
    mem_wdata = '0;
    cap_en    = 1'b0;
    idx_clr   = 1'b0;
    idx_inc   = 1'b0;
    acc_set   = 1'b0;
    acc_upd   = 1'b0;
    case (st_q)
      ST_IDLE:  st_nxt = ST_POLL;
      ST_POLL: begin
        mem_en = 1'b1;
        st_nxt = ST_LWAIT;
      end
      ST_LWAIT: begin
        cap_en = 1'b1;
        st_nxt = ST_LCHK;
      end
      ST_LCHK: begin
        if (rd_q == DATA_W'(LOCK_GO)) begin
          idx_clr = 1'b1;
          acc_set = 1'b1;
          st_nxt  = ST_RD;
        end else begin
          st_nxt  = ST_IDLE;
        end
      end
      ST_RD: begin
        mem_en   = 1'b1;
        mem_addr = DATA_ADDR + ADDR_W'(widx);
        st_nxt   = ST_RWAIT;
      end
      ST_RWAIT: begin
        cap_en = 1'b1;
        st_nxt = ST_CMP;
      end
      ST_CMP: begin
        acc_upd = 1'b1;
        if (widx == LAST_IDX) begin
          st_nxt  = ST_WRES;
        end else begin
          idx_inc = 1'b1;
          st_nxt  = ST_RD;
        end
      end
      ST_WRES: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = DATA_ADDR;
        mem_wdata = acc_q ? PASS_VAL : '0;
        st_nxt    = ST_WLOCK;
      end
      ST_WLOCK: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = DATA_W'(LOCK_DONE);
        st_nxt    = ST_IDLE;
      end
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      widx  <= '0;
      acc_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (idx_clr)      widx <= '0;
      else if (idx_inc) widx <= widx + 1'b1;
      if (acc_set)      acc_q <= 1'b1;
      else if (acc_upd) acc_q <= acc_q & word_ok;
    end
  end

  // Data-area read counter, cleared on each lock poll (checking aid)
  logic [IDX_W:0] rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
    end else if (mem_en && !mem_we) begin
      if (mem_addr == LOCK_ADDR) rd_cnt <= '0;
      else                       rd_cnt <= rd_cnt + 1'b1;
    end
  end

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && (mem_addr == DATA_ADDR || mem_addr == LOCK_ADDR))); // R5

  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == DATA_ADDR) |-> (mem_wdata == '0 || mem_wdata == PASS_VAL)); // R5

  AST_LOCK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == DATA_ADDR) |=>
      (mem_we && mem_addr == LOCK_ADDR && mem_wdata == DATA_W'(LOCK_DONE))); // R7

  AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == DATA_ADDR) |-> (rd_cnt == (IDX_W+1)'(NWORDS))); // R3

  AST_READ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && mem_addr != LOCK_ADDR) |->
      (mem_addr >= DATA_ADDR && mem_addr < DATA_ADDR + ADDR_W'(NWORDS))); // R3

endmodule

// File: rtl/keychk_top.sv
module keychk_top #(
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned BASE_WORD      = 0,
  parameter int unsigned DATA_OFS_BYTES = 8,
  parameter int unsigned KEY_LEN        = 12,
  parameter logic [KEY_LEN*8-1:0] KEY   = 96'h24_37_5A_6D_21_32_51_70_23_39_6B_58,
  parameter logic [DATA_W-1:0] PASS_VAL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned NB     = DATA_W / 8;
  localparam int unsigned NWORDS = (KEY_LEN + NB - 1) / NB;
  localparam int unsigned IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(BASE_WORD + 1);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_WORD + DATA_OFS_BYTES / NB);

  // Reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic              cap_en, word_ok;
  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    rd_q <= '0;
    else if (cap_en) rd_q <= mem_rdata;
  end

  keychk_match #(
    .DATA_W (DATA_W),
    .KEY_LEN(KEY_LEN),
    .KEY    (KEY),
    .IDX_W  (IDX_W)
  ) i_match (
    .word(rd_q),
    .widx(widx),
    .ok  (word_ok)
  );

  keychk_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NWORDS   (NWORDS),
    .IDX_W    (IDX_W),
    .LOCK_ADDR(LOCK_ADDR),
    .DATA_ADDR(DATA_ADDR),
    .PASS_VAL (PASS_VAL)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .rd_q     (rd_q),
    .word_ok  (word_ok),
    .cap_en   (cap_en),
    .widx     (widx),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  AST_QUIET_RESET: assert property (@(posedge clk)
    !rst_n |-> (!mem_en && !mem_we)); // R1

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |-> mem_en); // R2

endmodule

// File: tb/test_keychk_top.sv
module test_keychk_top;

  localparam int unsigned AW   = 6;
  localparam int unsigned DW   = 32;
  localparam int unsigned KL   = 10;
  localparam int unsigned NW   = (KL + 3) / 4;
  localparam int unsigned LOCK = 5;
  localparam int unsigned D0   = 6;
  localparam logic [KL*8-1:0] TKEY = 80'h1F_E2_5A_A5_00_FF_37_C8_91_6B;
  localparam logic [DW-1:0] PASS = 1;

  logic          clk, rst_n;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] mem [64];

  int total, bad, cyc;
  int nrd, nwr, bad_wr, order_bad, seq_bad, lat, t0, res_cyc;
  logic [AW-1:0] exp_addr;
  bit res_pend, done;

  keychk_top #(
    .ADDR_W(AW), .DATA_W(DW), .BASE_WORD(4), .DATA_OFS_BYTES(8),
    .KEY_LEN(KL), .KEY(TKEY), .PASS_VAL(PASS)
  ) i_keychk_top (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // RAM port B model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  // Port monitor, sampled between edges
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_en && !mem_we) begin
      if (mem_addr == AW'(LOCK)) begin
        exp_addr <= AW'(D0);
      end else begin
        if (mem_addr != exp_addr) order_bad <= order_bad + 1;
        if (mem_addr == AW'(D0)) t0 <= cyc;
        exp_addr <= mem_addr + 1'b1;
        nrd      <= nrd + 1;
      end
    end
    if (mem_en && mem_we) begin
      nwr <= nwr + 1;
      if (mem[LOCK] != 1) bad_wr <= bad_wr + 1;
      if (mem_addr == AW'(D0)) begin
        res_pend <= 1'b1;
        res_cyc  <= cyc;
      end else if (mem_addr == AW'(LOCK)) begin
        if (!res_pend || cyc != res_cyc + 1 || mem_wdata != 2) seq_bad <= seq_bad + 1;
        lat      <= cyc - t0;
        res_pend <= 1'b0;
      end else begin
        seq_bad <= seq_bad + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit key_ok(input logic [NW*32-1:0] img);
    for (int k = 0; k < KL; k++)
      if (img[8*k +: 8] != TKEY[8*k +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_chk(input logic [NW*32-1:0] img, input string tag);
    int n0, w;
    logic [DW-1:0] exp;
    @(negedge clk); #1;
    n0 = nrd;
    for (int i = 0; i < NW; i++) mem[D0 + i] = img[32*i +: 32];
    mem[LOCK] = 1;
    w = 0;
    while (mem[LOCK] != 2 && w < 300) begin
      @(negedge clk); #1;
      w++;
    end
    exp = key_ok(img) ? PASS : '0;
    chk(w < 300, {tag, " R7 lock done"}, w, 0);
    chk(mem[D0] == exp, {tag, " R5 verdict"}, mem[D0], exp);
    chk(nrd - n0 == NW, {tag, " R3 read count"}, nrd - n0, NW);
    chk(lat == 3 * NW + 1, {tag, " R9 latency"}, lat, 3 * NW + 1);
  endtask

  initial begin
    int r0, w0;
    logic [NW*32-1:0] good, img;
    total = 0; bad = 0; cyc = 0; done = 0;
    nrd = 0; nwr = 0; bad_wr = 0; order_bad = 0; seq_bad = 0;
    lat = 0; t0 = 0; res_cyc = 0; res_pend = 0; exp_addr = AW'(D0);
    for (int i = 0; i < 64; i++) mem[i] = '0;
    good = '0;
    good[KL*8-1:0] = TKEY;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!mem_en && !mem_we, "R1 in reset", {mem_en, mem_we}, 0);
    rst_n = 1'b1;
    #1;
    chk(!mem_en && !mem_we, "R1 after release", {mem_en, mem_we}, 0);

    // R2: lock held at 0 then 3: lock reads only, no writes
    r0 = nrd; w0 = nwr;
    repeat (100) @(negedge clk);
    mem[LOCK] = 3;
    repeat (100) @(negedge clk);
    chk(nwr == w0, "R2 no writes", nwr - w0, 0);
    chk(nrd == r0, "R2 no data reads", nrd - r0, 0);
    chk(exp_addr == AW'(D0), "R2 lock polled", exp_addr, D0);

    run_chk(good, "exact key");

    // R4: every single-bit flip of a compared byte fails
    for (int k = 0; k < KL; k++)
      for (int b = 0; b < 8; b++) begin
        img = good;
        img[8*k + b] = ~img[8*k + b];
        run_chk(img, "R4 bit flip");
      end

    // R4: byte-reversed words fail
    img = good;
    for (int i = 0; i < NW; i++) img[32*i +: 32] = {<<8{good[32*i +: 32]}};
    run_chk(img, "R4 byte swap");

    // R6: ignored bytes swept with correct key
    for (int p = KL; p < NW * 4; p++)
      for (int v = 0; v < 256; v++) begin
        img = good;
        img[8*p +: 8] = 8'(v);
        run_chk(img, "R6 ignored byte");
      end

    // R8: lock left at 2 starts nothing
    r0 = nrd; w0 = nwr;
    repeat (150) @(negedge clk);
    chk(nrd == r0 && nwr == w0, "R8 idle at lock 2", nrd - r0 + nwr - w0, 0);
    chk(mem[LOCK] == 2, "R8 lock kept", mem[LOCK], 2);
    img = good;
    img[0] = ~img[0];
    run_chk(img, "R8 restart");

    chk(bad_wr == 0, "R2 writes only under grant", bad_wr, 0);
    chk(order_bad == 0, "R3 read order", order_bad, 0);
    chk(seq_bad == 0, "R7 write sequence", seq_bad, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule